// File: doc/BRIEF.md
# Pretrigger Event Capture Recorder

The recorder watches a stream of three-axis samples (one byte each for X, Y and Z) and keeps a rolling history of the most recent ones. When a trigger pulse is accepted, it writes one event into the next free slot of a sample memory. An event starts with six header words that are captured at the trigger, then the samples from just before the trigger, then the samples that follow it, until the slot is full. The memory is split into equal power-of-two slots. The slot length is selected by a 3-bit length field T, and the pretrigger share of each slot by a 4-bit field P. With the full-size setting `ADDR_W = 13` the memory holds 8192 samples per axis, and T = 4 gives 128 events of 64 samples. The default `ADDR_W = 11` builds a quarter-size memory with the same rules.

Stored data is read through a pointer. The output lanes always show the word at the pointer. A read acknowledge on the Z lane advances the pointer, so a reader that alternates between the XY lane and the Z lane walks through memory in order. A running count of triggers is kept, and it includes triggers that could not be stored. A clear command empties the memory, zeroes both counters and loads a new length and pretrigger setting.

Top module: `cap_recorder`

## Requirements
- R1: After reset, the trigger count is 0, the stored-event count is 0 and the read pointer is 0. The active setting is T = 2 and P = 2.
- R2: The slot length is NL = 2^(ADDR_W-3-T) and the number of slots is NE = 2^(3+T). Event k occupies addresses k·NL to k·NL+NL-1.
- R2 (continued): Offsets 0 to 5 of a slot hold the header words in this order: peak sum-of-squares, time, date, temperature, supply, auxiliary ADC. Header word j is bits [16j+15:16j] of `hdr_vals`, captured in the cycle the trigger is accepted. Its low byte is stored on the X lane, its high byte on the Y lane, and the Z lane is 0.
- R3: The pretrigger count is NPRE = (NL/16)·P − 6. When that value is negative, NPRE is 0 and posttrigger data follows the header directly. Let s be the number of samples accepted before the trigger cycle; a sample that arrives in the trigger cycle is posttrigger. Then offset j ≥ 6 holds sample number s − NPRE + (j − 6).
- R4: Every trigger pulse increments the 16-bit trigger count, which wraps modulo 2^16. A trigger in the same cycle as a clear leaves the count at 0.
- R5: A trigger that arrives while an event is being filled is counted but starts no event. The event being filled is completed normally.
- R6: Once NE events are stored, a trigger is counted but writes nothing. The stored-event count stays at NE and earlier slots keep their contents.
- R7: A clear zeroes both counts and abandons any event being filled. It loads T from `cfg_len` and P from `cfg_pre`. A T above ADDR_W−6 is replaced by ADDR_W−6, which keeps every slot at least 8 words long. The next event after a clear goes to slot 0.
- R8: `rd_ptr` changes one cycle after a request. The lanes `rd_xy` ({Y,X}) and `rd_z` show the word at `rd_ptr`. `z_ack` advances the pointer by one, and `ptr_ld` loads `ptr_val`. A load takes priority over an acknowledge in the same cycle.
- R9: The stored-event count rises by one in the cycle after the last word of an event is written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| smp_valid | input | 1 | New sample on the X/Y/Z inputs |
| smp_x | input | 8 | X-axis sample |
| smp_y | input | 8 | Y-axis sample |
| smp_z | input | 8 | Z-axis sample |
| trig | input | 1 | Trigger pulse |
| hdr_vals | input | 96 | Six 16-bit header values, word j at bits [16j+15:16j] |
| cfg_len | input | 3 | Slot-length field T, loaded on clear |
| cfg_pre | input | 4 | Pretrigger field P, loaded on clear |
| clr | input | 1 | Clear memory bookkeeping and counters, load the setting |
| ptr_ld | input | 1 | Load the read pointer |
| ptr_val | input | ADDR_W | Value for the read pointer |
| z_ack | input | 1 | Z lane read, advances the read pointer |
| rd_ptr | output | ADDR_W | Current read pointer |
| rd_xy | output | 16 | Y byte (high) and X byte (low) at the pointer |
| rd_z | output | 8 | Z byte at the pointer |
| trig_count | output | 16 | Triggers since the last clear |
| event_count | output | ADDR_W-2 | Stored events |

## Verification
The checks assume three things about the inputs. Samples are already in the history before a trigger whose pretrigger window reaches back that far. The configuration inputs matter only in a clearing cycle. Reads are made only while no event is being filled. The bench first streams samples for longer than the largest window. It then waits out each event's fill time before moving the pointer, and it raises a trigger only in cycles with no sample, so that the sample count s in R3 is unambiguous. The history ring must never overrun its read position. This follows from the header taking six cycles and the copy draining one word per cycle, and a property watches for it while samples arrive on every other cycle.

// File: rtl/cap_pkg.sv
package cap_pkg;
  localparam int HDR_WORDS = 6;

  typedef struct packed {
    logic [7:0] z;
    logic [7:0] y;
    logic [7:0] x;
  } smp_t;

  typedef enum logic [1:0] {
    S_IDLE = 2'd0,
    S_HDR  = 2'd1,
    S_DATA = 2'd2
  } seq_state_t;
endpackage

// File: rtl/cap_history.sv
module cap_history
  import cap_pkg::*;
#(
  parameter int ADDR_W = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  smp_t              wr_data,
  input  logic              start,
  input  logic [ADDR_W-4:0] npre,
  input  logic              stop,
  input  logic              pop,
  output logic              avail,
  output smp_t              rd_data
);
  localparam int HW = ADDR_W - 3;
  localparam int HD = 1 << HW;

  smp_t          ring [HD];
  logic [HW-1:0] wp_q, wp_d;
  logic [HW-1:0] rp_q, rp_d;
  logic          live_q, live_d;

  always_comb begin
    wp_d   = wr_en ? wp_q + HW'(1) : wp_q;
    rp_d   = rp_q;
    live_d = live_q;
    if (start) begin
      rp_d   = wp_q - npre;
      live_d = 1'b1;
    end else if (pop) begin
      rp_d = rp_q + HW'(1);
    end
    if (stop) live_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q   <= '0;
      rp_q   <= '0;
      live_q <= 1'b0;
    end else begin
      wp_q   <= wp_d;
      rp_q   <= rp_d;
      live_q <= live_d;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) ring[wp_q] <= wr_data;
  end

  assign avail   = live_q && (rp_q != wp_q);
  assign rd_data = ring[rp_q];

  // R3: the copy position is never overtaken by incoming samples
  a_r3_ring_no_overrun: assert property (@(posedge clk) disable iff (!rst_n)
    (live_q && wr_en && !pop) |-> ((wp_q + HW'(1)) != rp_q));
endmodule

// File: rtl/cap_store.sv
module cap_store
  import cap_pkg::*;
#(
  parameter int ADDR_W = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  smp_t              wdata,
  input  logic              ptr_ld,
  input  logic [ADDR_W-1:0] ptr_val,
  input  logic              ptr_inc,
  output logic [ADDR_W-1:0] rd_ptr,
  output smp_t              rd_word
);
  localparam int DEPTH = 1 << ADDR_W;

  smp_t              mem [DEPTH];
  logic [ADDR_W-1:0] ptr_q, ptr_d;

  always_comb begin
    ptr_d = ptr_q;
    if (ptr_ld)       ptr_d = ptr_val;
    else if (ptr_inc) ptr_d = ptr_q + ADDR_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ptr_q <= '0;
    else        ptr_q <= ptr_d;
  end

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rd_ptr  = ptr_q;
  assign rd_word = mem[ptr_q];

  // R8: without a request the pointer holds
  a_r8_ptr_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!ptr_ld && !ptr_inc) |=> $stable(ptr_q));
endmodule

// File: rtl/cap_sequencer.sv
module cap_sequencer
  import cap_pkg::*;
#(
  parameter int ADDR_W = 11
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      trig,
  input  logic                      clr,
  input  logic [2:0]                cfg_len,
  input  logic [3:0]                cfg_pre,
  input  logic [HDR_WORDS*16-1:0]   hdr_vals,
  input  logic                      hist_avail,
  input  smp_t                      hist_data,
  output logic                      hist_start,
  output logic [ADDR_W-4:0]         hist_npre,
  output logic                      hist_pop,
  output logic                      hist_stop,
  output logic                      mem_we,
  output logic [ADDR_W-1:0]         mem_waddr,
  output smp_t                      mem_wdata,
  output logic [15:0]               trig_count,
  output logic [ADDR_W-3:0]         event_count
);
  localparam int HW = ADDR_W - 3;
  localparam int CW = ADDR_W - 2;
  localparam logic [2:0] TMAX = 3'(ADDR_W - 6);

  seq_state_t              state_q, state_d;
  logic [HW-1:0]           off_q, off_d;
  logic [2:0]              t_q, t_d;
  logic [3:0]              p_q, p_d;
  logic [HDR_WORDS*16-1:0] hdr_q, hdr_d;
  logic [15:0]             cnt_q, cnt_d;
  logic [CW-1:0]           ev_q, ev_d;

  logic [3:0]        sh;
  logic [HW:0]       nl;
  logic [HW-1:0]     nl_m1, prod, npre;
  logic [CW-1:0]     ne;
  logic [ADDR_W-1:0] base;
  logic              full, accept, last;
  logic [15:0]       hdr_word;

  // Slot geometry from the active setting
  always_comb begin
    sh    = 4'(HW) - {1'b0, t_q};
    nl    = (HW+1)'(1) << sh;
    nl_m1 = HW'(nl - (HW+1)'(1));
    prod  = HW'(nl >> 4) * HW'(p_q);
    npre  = (prod > HW'(6)) ? prod - HW'(6) : '0;
    ne    = CW'(1) << ({1'b0, t_q} + 4'd3);
    full  = (ev_q == ne);
    base  = ADDR_W'(ev_q) << sh;
  end

  assign accept   = trig && !clr && (state_q == S_IDLE) && !full;
  assign hdr_word = hdr_q[{off_q[2:0], 4'b0000} +: 16];

  always_comb begin
    state_d   = state_q;
    off_d     = off_q;
    t_d       = t_q;
    p_d       = p_q;
    hdr_d     = hdr_q;
    cnt_d     = cnt_q;
    ev_d      = ev_q;
    mem_we    = 1'b0;
    mem_wdata = '0;
    hist_pop  = 1'b0;
    last      = 1'b0;
    if (trig) cnt_d = cnt_q + 16'd1;
    case (state_q)
      S_IDLE: begin
        if (accept) begin
          state_d = S_HDR;
          off_d   = '0;
          hdr_d   = hdr_vals;
        end
      end
      S_HDR: begin
        mem_we      = 1'b1;
        mem_wdata.x = hdr_word[7:0];
        mem_wdata.y = hdr_word[15:8];
        mem_wdata.z = 8'h00;
        off_d       = off_q + HW'(1);
        if (off_q == HW'(HDR_WORDS - 1)) state_d = S_DATA;
      end
      S_DATA: begin
        if (hist_avail) begin
          mem_we    = 1'b1;
          hist_pop  = 1'b1;
          mem_wdata = hist_data;
          off_d     = off_q + HW'(1);
          if (off_q == nl_m1) begin
            last    = 1'b1;
            state_d = S_IDLE;
            ev_d    = ev_q + CW'(1);
          end
        end
      end
      default: state_d = S_IDLE;
    endcase
    if (clr) begin
      state_d = S_IDLE;
      cnt_d   = '0;
      ev_d    = '0;
      t_d     = (cfg_len > TMAX) ? TMAX : cfg_len;
      p_d     = cfg_pre;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      off_q   <= '0;
      t_q     <= 3'd2;
      p_q     <= 4'd2;
      hdr_q   <= '0;
      cnt_q   <= '0;
      ev_q    <= '0;
    end else begin
      state_q <= state_d;
      off_q   <= off_d;
      t_q     <= t_d;
      p_q     <= p_d;
      hdr_q   <= hdr_d;
      cnt_q   <= cnt_d;
      ev_q    <= ev_d;
    end
  end

  assign mem_waddr   = base + ADDR_W'(off_q);
  assign hist_start  = accept;
  assign hist_npre   = npre;
  assign hist_stop   = clr | last;
  assign trig_count  = cnt_q;
  assign event_count = ev_q;

  // R2: header words carry nothing on the Z lane
  a_r2_header_z_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && state_q == S_HDR) |-> (mem_wdata.z == 8'h00));

  // R6: a full memory refuses a new event
  a_r6_full_stays_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (trig && !clr && full && state_q == S_IDLE) |=> (state_q == S_IDLE));

  // R5: while the header is written no event completes
  a_r5_busy_no_complete: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == S_HDR && !clr) |=> $stable(ev_q));

  // R9: the stored count only moves by one, apart from a clear
  a_r9_event_step: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(ev_q) && !$past(clr)) |-> (ev_q == $past(ev_q) + CW'(1)));
endmodule

// File: rtl/cap_recorder.sv
module cap_recorder
  import cap_pkg::*;
#(
  parameter int ADDR_W = 11
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    smp_valid,
  input  logic [7:0]              smp_x,
  input  logic [7:0]              smp_y,
  input  logic [7:0]              smp_z,
  input  logic                    trig,
  input  logic [HDR_WORDS*16-1:0] hdr_vals,
  input  logic [2:0]              cfg_len,
  input  logic [3:0]              cfg_pre,
  input  logic                    clr,
  input  logic                    ptr_ld,
  input  logic [ADDR_W-1:0]       ptr_val,
  input  logic                    z_ack,
  output logic [ADDR_W-1:0]       rd_ptr,
  output logic [15:0]             rd_xy,
  output logic [7:0]              rd_z,
  output logic [15:0]             trig_count,
  output logic [ADDR_W-3:0]       event_count
);
  smp_t              in_smp, hist_data, mem_wdata, rd_word;
  logic              hist_start, hist_pop, hist_stop, hist_avail, mem_we;
  logic [ADDR_W-4:0] hist_npre;
  logic [ADDR_W-1:0] mem_waddr;

  assign in_smp = '{z: smp_z, y: smp_y, x: smp_x};

  cap_history #(.ADDR_W(ADDR_W)) u_hist (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (smp_valid),
    .wr_data (in_smp),
    .start   (hist_start),
    .npre    (hist_npre),
    .stop    (hist_stop),
    .pop     (hist_pop),
    .avail   (hist_avail),
    .rd_data (hist_data)
  );

  cap_sequencer #(.ADDR_W(ADDR_W)) u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .trig        (trig),
    .clr         (clr),
    .cfg_len     (cfg_len),
    .cfg_pre     (cfg_pre),
    .hdr_vals    (hdr_vals),
    .hist_avail  (hist_avail),
    .hist_data   (hist_data),
    .hist_start  (hist_start),
    .hist_npre   (hist_npre),
    .hist_pop    (hist_pop),
    .hist_stop   (hist_stop),
    .mem_we      (mem_we),
    .mem_waddr   (mem_waddr),
    .mem_wdata   (mem_wdata),
    .trig_count  (trig_count),
    .event_count (event_count)
  );

  cap_store #(.ADDR_W(ADDR_W)) u_store (
    .clk     (clk),
    .rst_n   (rst_n),
    .we      (mem_we),
    .waddr   (mem_waddr),
    .wdata   (mem_wdata),
    .ptr_ld  (ptr_ld),
    .ptr_val (ptr_val),
    .ptr_inc (z_ack),
    .rd_ptr  (rd_ptr),
    .rd_word (rd_word)
  );

  assign rd_xy = {rd_word.y, rd_word.x};
  assign rd_z  = rd_word.z;
endmodule

// File: tb/sim_cap_recorder.sv
`timescale 1ns/1ps
module sim_cap_recorder;
  localparam int AW = 11;

  logic clk = 1'b0;
  logic rst_n, smp_valid, trig, clr, ptr_ld, z_ack;
  logic [7:0] smp_x, smp_y, smp_z;
  logic [95:0] hdr_vals;
  logic [2:0] cfg_len;
  logic [3:0] cfg_pre;
  logic [AW-1:0] ptr_val, rd_ptr;
  logic [15:0] rd_xy, trig_count;
  logic [7:0] rd_z;
  logic [AW-3:0] event_count;

  int total = 0, bad = 0, seq = 0;
  logic phase = 1'b0;
  int st_log [256];

  always #2.5 clk = ~clk;

  cap_recorder #(.ADDR_W(AW)) u0 (
    .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_x(smp_x), .smp_y(smp_y),
    .smp_z(smp_z), .trig(trig), .hdr_vals(hdr_vals), .cfg_len(cfg_len), .cfg_pre(cfg_pre),
    .clr(clr), .ptr_ld(ptr_ld), .ptr_val(ptr_val), .z_ack(z_ack), .rd_ptr(rd_ptr),
    .rd_xy(rd_xy), .rd_z(rd_z), .trig_count(trig_count), .event_count(event_count));

  function automatic logic [23:0] smp_at(int n);
    logic [7:0] x, y, z;
    x = 8'(n);
    y = 8'(n * 7 + 3);
    z = 8'(n * 13 + 77);
    return {z, y, x};
  endfunction

  function automatic logic [95:0] mkhdr(int k);
    logic [95:0] r;
    for (int j = 0; j < 6; j++) r[j*16 +: 16] = 16'(k * 257 + j * 4369 + 1);
    return r;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  // called at a negedge; returns just after the next posedge
  task automatic drive(logic tg, logic ack, logic ld, int ldv, logic cl);
    logic [23:0] s;
    s = smp_at(seq);
    smp_valid = phase & ~tg;
    {smp_z, smp_y, smp_x} = s;
    trig = tg; z_ack = ack; ptr_ld = ld; ptr_val = AW'(ldv); clr = cl;
    @(posedge clk);
    if (smp_valid) seq++;
    phase = ~phase;
  endtask

  task automatic cyc(logic tg, logic ack, logic ld, int ldv, logic cl);
    @(negedge clk);
    drive(tg, ack, ld, ldv, cl);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) cyc(0, 0, 0, 0, 0);
  endtask

  task automatic fire(int k, output int st);
    @(negedge clk);
    hdr_vals = mkhdr(k);
    st = seq;
    drive(1, 0, 0, 0, 0);
    @(negedge clk);
    hdr_vals = mkhdr(k + 999);
    drive(0, 0, 0, 0, 0);
  endtask

  task automatic do_clr(logic [2:0] t, logic [3:0] p);
    @(negedge clk);
    cfg_len = t; cfg_pre = p;
    drive(0, 0, 0, 0, 1);
  endtask

  task automatic chk_event(string req, int base, int nl, int npre, int st, logic [95:0] h);
    logic [23:0] e;
    cyc(0, 0, 1, base, 0);
    for (int j = 0; j < nl; j++) begin
      @(negedge clk);
      if (j < 6) e = {8'h00, h[j*16+8 +: 8], h[j*16 +: 8]};
      else       e = smp_at(st - npre + (j - 6));
      chk(req, {8'h0, rd_z, rd_xy}, {8'h0, e});
      drive(0, 1, 0, 0, 0);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    $display("FAIL watchdog act=running exp=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int s0, s1, sx;
    rst_n = 1'b0; smp_valid = 0; trig = 0; clr = 0; ptr_ld = 0; z_ack = 0;
    smp_x = 0; smp_y = 0; smp_z = 0; hdr_vals = '0; cfg_len = 0; cfg_pre = 0; ptr_val = '0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    // R1 reset state
    @(negedge clk);
    chk("R1 trig_count", 32'(trig_count), 0);
    chk("R1 event_count", 32'(event_count), 0);
    chk("R1 rd_ptr", 32'(rd_ptr), 0);
    idle(200);
    // R1 default T=2 P=2: NL=64, NPRE=2; R2/R3 layout
    fire(1, s0);
    idle(150);
    chk("R9 event_count after one", 32'(event_count), 1);
    chk_event("R3 default event", 0, 64, 2, s0, mkhdr(1));
    // R5 trigger during fill
    fire(2, s1);
    idle(4);
    fire(3, sx);
    idle(150);
    chk("R5 trig_count", 32'(trig_count), 3);
    chk("R5 event_count", 32'(event_count), 2);
    chk_event("R2 slot1 event", 64, 64, 2, s1, mkhdr(2));
    // R7 clear mid-fill, new config T=3 P=15: NL=32, NPRE=24
    fire(4, sx);
    idle(2);
    do_clr(3'd3, 4'd15);
    @(negedge clk);
    chk("R7 trig_count cleared", 32'(trig_count), 0);
    chk("R7 event_count cleared", 32'(event_count), 0);
    idle(40);
    fire(5, s0);
    idle(80);
    chk("R4 trig_count one", 32'(trig_count), 1);
    chk_event("R3 deep pretrigger slot0", 0, 32, 24, s0, mkhdr(5));
    fire(6, s1);
    idle(80);
    chk_event("R2 deep pretrigger slot1", 32, 32, 24, s1, mkhdr(6));
    // R3 negative pretrigger: T=2 P=1 -> NPRE=0
    do_clr(3'd2, 4'd1);
    fire(7, s0);
    idle(150);
    chk_event("R3 no pretrigger", 0, 64, 0, s0, mkhdr(7));
    // R7 clamp T=7 -> 5: NL=8, NE=256; R6 full
    do_clr(3'd7, 4'd0);
    for (int k = 0; k < 256; k++) begin
      fire(100 + k, st_log[k]);
      idle(18);
    end
    chk("R7 clamp event_count", 32'(event_count), 256);
    for (int k = 0; k < 3; k++) begin
      fire(900 + k, sx);
      idle(18);
    end
    chk("R6 trig_count beyond full", 32'(trig_count), 259);
    chk("R6 event_count held", 32'(event_count), 256);
    chk_event("R6 slot0 untouched", 0, 8, 0, st_log[0], mkhdr(100));
    chk_event("R2 slot1 short", 8, 8, 0, st_log[1], mkhdr(101));
    chk_event("R6 last slot", 2040, 8, 0, st_log[255], mkhdr(355));
    // R8 pointer control
    cyc(0, 0, 1, 100, 0);
    @(negedge clk);
    chk("R8 load", 32'(rd_ptr), 100);
    drive(0, 1, 0, 0, 0);
    @(negedge clk);
    chk("R8 increment", 32'(rd_ptr), 101);
    drive(0, 1, 1, 500, 0);
    @(negedge clk);
    chk("R8 load priority", 32'(rd_ptr), 500);
    drive(0, 0, 0, 0, 0);
    @(negedge clk);
    chk("R8 hold", 32'(rd_ptr), 500);
    // R4 trigger with clear in the same cycle
    @(negedge clk);
    cfg_len = 3'd2; cfg_pre = 4'd2;
    drive(1, 0, 0, 0, 1);
    @(negedge clk);
    chk("R4 clear wins", 32'(trig_count), 0);
    chk("R7 no event after clear", 32'(event_count), 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule